// File: doc/BRIEF.md
# Pending miss request table

This block sits beside a load/store unit's data cache and keeps track of cache-block misses that are waiting for memory. Each miss arrives with an address and an access tag that identifies the deferred load or store. The first miss to a block claims a free entry and sends one memory request. Later misses to the same 128-byte block join that entry's list and send nothing.

Each memory request carries the entry index as its subid. When the fill comes back, that subid selects the entry directly and no address search is done. In the fill cycle the table raises a lock for the block, so the cache keeps the line and every replayed access hits. From the next cycle on, the table sends the merged tags back one per cycle, in the order they arrived. The entry is freed on its final replay, and that same cycle marks the end of the lock.

Top module: `miss_track_table`

## Requirements
- R1: After reset every entry is free: there is no replay, no lock and no memory request, and a miss is not refused.
- R2: An accepted miss whose block (address bits 7 and up) matches no live entry claims the lowest-numbered free entry. In the same cycle it raises `mem_req_valid`, with `mem_req_subid` equal to that entry index and `mem_req_blk` equal to the block.
- R3: An accepted miss whose block matches a live entry, either waiting or replaying, is appended to that entry's list and raises no memory request.
- R4: `miss_full` is high when the matching entry has already taken SLOTS accesses since it was claimed, or when nothing matches and no entry is free. A refused miss changes nothing: it makes no request and is never replayed.
- R5: A fill whose subid names a waiting entry raises `lock_valid` in the same cycle, with `lock_blk` equal to that entry's block.
- R6: Replays begin in the cycle after the fill. They run one per cycle in arrival order, and each shows the access tag on `replay_tag` and the block on `replay_blk`.
- R7: `replay_last` is high on an entry's final replay, and the entry is free after that edge, so a later miss to the block claims a new entry and requests memory again.
- R8: A miss that merges in its entry's fill cycle, or while its entry is replaying, is replayed after the earlier tags. If it merges during the final replay, `replay_last` stays low and the entry stays live.
- R9: When more than one entry is replaying, the lowest-numbered entry drains first, whatever the order of the fills.
- R10: The low 7 address bits (the byte offset within the block) play no part in matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A miss is offered this cycle |
| miss_addr | input | ADDR_W | Byte address of the miss |
| miss_tag | input | TAG_W | Access tag to hand back on replay |
| miss_full | output | 1 | The offered miss would be refused |
| mem_req_valid | output | 1 | Memory request for a newly claimed entry |
| mem_req_subid | output | log2(ENTRIES) | Entry index sent with the request |
| mem_req_blk | output | ADDR_W-7 | Block address requested |
| fill_valid | input | 1 | A fill returns this cycle |
| fill_subid | input | log2(ENTRIES) | Entry named by the fill |
| lock_valid | output | 1 | Lock the filled line |
| lock_blk | output | ADDR_W-7 | Block to lock |
| replay_valid | output | 1 | A merged access is replayed |
| replay_tag | output | TAG_W | Tag of the replayed access |
| replay_blk | output | ADDR_W-7 | Block of the replayed access |
| replay_last | output | 1 | Final replay of the entry; the lock ends |

## Verification
`miss_full`, the memory request and the lock depend only on the inputs and the state of the current cycle. They are due in the same cycle as the miss or the fill. A fill or a merge changes the replay stream only after the next rising edge, so the first replay is due one cycle after its fill. The bench changes inputs just after the falling edge and compares every output 1 ns later, before the rising edge. Its queue-based model of the entries advances only after that edge, so each comparison uses the state the design holds in that cycle.

// File: rtl/miss_track_table.sv
module miss_track_table #(
  parameter int ENTRIES = 4,
  parameter int SLOTS   = 4,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 7,
  parameter int TAG_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       miss_valid,
  input  logic [ADDR_W-1:0]          miss_addr,
  input  logic [TAG_W-1:0]           miss_tag,
  output logic                       miss_full,
  output logic                       mem_req_valid,
  output logic [$clog2(ENTRIES)-1:0] mem_req_subid,
  output logic [ADDR_W-OFF_W-1:0]    mem_req_blk,
  input  logic                       fill_valid,
  input  logic [$clog2(ENTRIES)-1:0] fill_subid,
  output logic                       lock_valid,
  output logic [ADDR_W-OFF_W-1:0]    lock_blk,
  output logic                       replay_valid,
  output logic [TAG_W-1:0]           replay_tag,
  output logic [ADDR_W-OFF_W-1:0]    replay_blk,
  output logic                       replay_last
);
  localparam int IW = $clog2(ENTRIES);
  localparam int BW = ADDR_W - OFF_W;
  localparam int CW = $clog2(SLOTS + 1);
  localparam int PW = $clog2(SLOTS);

  typedef enum logic [1:0] {E_FREE, E_WAIT, E_PLAY} ent_t;

  ent_t             st  [ENTRIES];
  logic [BW-1:0]    blk [ENTRIES];
  logic [CW-1:0]    cnt [ENTRIES];
  logic [PW-1:0]    rd  [ENTRIES];
  logic [TAG_W-1:0] tg  [ENTRIES][SLOTS];

  logic [BW-1:0] mb;
  logic          hit, free_any, play_any, dup;
  logic [IW-1:0] hit_idx, free_idx, play_idx;
  logic          acc, merge, alloc;

  assign mb = miss_addr[ADDR_W-1:OFF_W];

  always_comb begin
    hit = 1'b0; hit_idx = '0;
    free_any = 1'b0; free_idx = '0;
    play_any = 1'b0; play_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (st[i] != E_FREE && blk[i] == mb) begin hit = 1'b1; hit_idx = IW'(i); end
      if (st[i] == E_FREE) begin free_any = 1'b1; free_idx = IW'(i); end
      if (st[i] == E_PLAY) begin play_any = 1'b1; play_idx = IW'(i); end
    end
  end

  assign miss_full = hit ? (cnt[hit_idx] == CW'(SLOTS)) : !free_any;
  assign acc   = miss_valid && !miss_full;
  assign merge = acc && hit;
  assign alloc = acc && !hit;

  assign mem_req_valid = alloc;
  assign mem_req_subid = free_idx;
  assign mem_req_blk   = mb;

  assign lock_valid = fill_valid && st[fill_subid] == E_WAIT;
  assign lock_blk   = blk[fill_subid];

  assign replay_valid = play_any;
  assign replay_tag   = tg[play_idx][rd[play_idx]];
  assign replay_blk   = blk[play_idx];
  assign replay_last  = play_any && (CW'(rd[play_idx]) + CW'(1) == cnt[play_idx])
                        && !(merge && hit_idx == play_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        st[i] <= E_FREE; blk[i] <= '0; cnt[i] <= '0; rd[i] <= '0;
        for (int s = 0; s < SLOTS; s++) tg[i][s] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (play_any && play_idx == IW'(i)) begin
          if (replay_last) st[i] <= E_FREE;
          else             rd[i] <= rd[i] + PW'(1);
        end
        if (fill_valid && fill_subid == IW'(i) && st[i] == E_WAIT) st[i] <= E_PLAY;
        if (merge && hit_idx == IW'(i)) begin
          tg[i][cnt[i][PW-1:0]] <= miss_tag;
          cnt[i] <= cnt[i] + CW'(1);
        end
        if (alloc && free_idx == IW'(i)) begin
          st[i] <= E_WAIT; blk[i] <= mb; tg[i][0] <= miss_tag;
          cnt[i] <= CW'(1); rd[i] <= '0;
        end
      end
    end
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (st[i] != E_FREE && st[j] != E_FREE && blk[i] == blk[j]) dup = 1'b1;
  end

  AST_REQ_OPENS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> st[$past(mem_req_subid)] == E_WAIT); // R2
  AST_UNIQUE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !dup); // R3
  AST_FILL_TARGETS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> st[fill_subid] == E_WAIT); // R5
  AST_REPLAY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> CW'(rd[play_idx]) < cnt[play_idx]); // R6
  AST_LAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    replay_last |=> st[$past(play_idx)] == E_FREE); // R7
endmodule

// File: tb/sim_miss_track_table.sv
module sim_miss_track_table;
  localparam int ENT = 4;
  localparam int SL  = 4;
  localparam int AW  = 32;
  localparam int TW  = 8;
  localparam int BW  = AW - 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0;
  logic [TW-1:0] miss_tag = '0;
  logic fill_valid = 1'b0;
  logic [1:0] fill_subid = '0;
  logic miss_full, mem_req_valid, lock_valid, replay_valid, replay_last;
  logic [1:0] mem_req_subid;
  logic [BW-1:0] mem_req_blk, lock_blk, replay_blk;
  logic [TW-1:0] replay_tag;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  miss_track_table #(.ENTRIES(ENT), .SLOTS(SL), .ADDR_W(AW), .OFF_W(7), .TAG_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_tag(miss_tag), .miss_full(miss_full),
    .mem_req_valid(mem_req_valid), .mem_req_subid(mem_req_subid), .mem_req_blk(mem_req_blk),
    .fill_valid(fill_valid), .fill_subid(fill_subid),
    .lock_valid(lock_valid), .lock_blk(lock_blk),
    .replay_valid(replay_valid), .replay_tag(replay_tag), .replay_blk(replay_blk),
    .replay_last(replay_last));

  bit          live [ENT];
  bit          waiting [ENT];
  longint      mblk [ENT];
  int          mtot [ENT];
  int          mq [ENT][$];

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit mv, longint addr, int tag, bit fv, int fs);
    longint b;
    int m, fr, r;
    bit full, acc, last;
    miss_valid = mv; miss_addr = AW'(addr); miss_tag = TW'(tag);
    fill_valid = fv; fill_subid = 2'(fs);
    #1;
    b = addr >> 7;
    m = -1; fr = -1; r = -1;
    for (int i = ENT - 1; i >= 0; i--) begin
      if (live[i] && mblk[i] == b) m = i;
      if (!live[i]) fr = i;
      if (live[i] && !waiting[i]) r = i;
    end
    full = (m >= 0) ? (mtot[m] >= SL) : (fr < 0);
    acc  = mv && !full;
    last = (r >= 0) && (mq[r].size() == 1) && !(acc && m == r);
    chk(req, "miss_full", miss_full, full);
    chk(req, "mem_req_valid", mem_req_valid, acc && m < 0);
    if (acc && m < 0) begin
      chk(req, "mem_req_subid", mem_req_subid, fr);
      chk(req, "mem_req_blk", mem_req_blk, b);
    end
    chk(req, "lock_valid", lock_valid, fv);
    if (fv) chk(req, "lock_blk", lock_blk, mblk[fs]);
    chk(req, "replay_valid", replay_valid, r >= 0);
    if (r >= 0) begin
      chk(req, "replay_tag", replay_tag, mq[r][0]);
      chk(req, "replay_blk", replay_blk, mblk[r]);
    end
    chk(req, "replay_last", replay_last, last);
    @(posedge clk);
    if (r >= 0) void'(mq[r].pop_front());
    if (acc) begin
      if (m >= 0) begin
        mq[m].push_back(tag); mtot[m]++;
      end else begin
        live[fr] = 1; waiting[fr] = 1; mblk[fr] = b;
        mq[fr].delete(); mq[fr].push_back(tag); mtot[fr] = 1;
      end
    end
    if (fv) waiting[fs] = 0;
    if (r >= 0 && mq[r].size() == 0) live[r] = 0;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENT; i++) begin live[i] = 0; waiting[i] = 0; mblk[i] = 0; mtot[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 0);
    step("R2", 1, 'h1000, 1, 0, 0);
    step("R10", 1, 'h1010, 2, 0, 0);
    step("R10", 1, 'h107F, 3, 0, 0);
    step("R2", 1, 'h2000, 10, 0, 0);
    step("R2", 1, 'h3000, 20, 0, 0);
    step("R2", 1, 'h4000, 30, 0, 0);
    step("R4", 1, 'h5000, 40, 0, 0);
    step("R3", 1, 'h1004, 4, 0, 0);
    step("R4", 1, 'h1008, 5, 0, 0);
    step("R8", 1, 'h2008, 11, 1, 1);
    step("R6", 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 0);
    step("R6", 0, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 3);
    step("R9", 0, 0, 0, 1, 2);
    step("R4", 1, 'h1040, 6, 0, 0);
    step("R9", 0, 0, 0, 0, 0);
    step("R8", 1, 'h4010, 31, 0, 0);
    step("R9", 1, 'h4020, 32, 0, 0);
    step("R8", 0, 0, 0, 0, 0);
    step("R8", 1, 'h4040, 33, 0, 0);
    step("R7", 0, 0, 0, 0, 0);
    step("R7", 1, 'h1000, 50, 0, 0);
    step("R7", 1, 'h4000, 51, 0, 0);
    step("R5", 0, 0, 0, 1, 1);
    step("R6", 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule